// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Port with Shared-Port Arbitration

This block gives software an eight-bit control register through which it drives a one-bit serial EEPROM by hand. The EEPROM sits behind a memory port that other requesters also use, so software first sets a request bit. As soon as the shared port is not busy, the block takes ownership and raises a ready flag that confirms the grant, with no delay of its own. From then on, the chip-select, clock and data-out bits of the register appear directly on the EEPROM pins. The EEPROM's serial output is synchronized and read back in the lowest register bit.

After the grant, every register write restarts a pacing timer and clears the ready flag. Ready returns once a fixed interval has elapsed (800 ns by default, derived from the clock frequency), so software can poll the flag between clock edges that it generates itself. Clearing the request bit drops the pins at once and releases the shared port. A separate pair of bits carries a request/acknowledge handshake to external arbitration logic. All protocol sequencing, such as opcodes and addresses, stays in software.

Top module: `seeprom_port`

## Requirements
- R1: After reset the register reads 0x00, the three EEPROM pins are low, `port_owned` is low and `ext_req` is low.
- R2: Register layout: bit 7 external acknowledge (read-only), bit 6 external request, bit 5 port request, bit 4 ready (read-only), bit 3 chip select, bit 2 clock, bit 1 data out, bit 0 data in (read-only). Bits 6, 5, 3, 2 and 1 read back the last value written.
- R3: `port_owned` rises only on a clock edge where the request bit is set and `mem_busy` is low. Once owned, the port is held regardless of `mem_busy`.
- R4: The first ready after a grant needs no pacing delay. Ready reads 1 in the same cycle that `port_owned` first reads 1.
- R5: The pins `ee_cs`, `ee_sk` and `ee_data_out` follow register bits 3, 2 and 1 only while the port is owned and the request bit is set. Otherwise they are low.
- R6: A register write while the port is owned makes ready read 0 from that write's clock edge. Ready reads 1 again exactly PACE_CYC edges later, where PACE_CYC = CLK_HZ/1000 * PACE_NS / 1000000 (40 at the defaults).
- R7: A write that clears the request bit forces the pins and ready low from its own edge. Ownership is released on the following edge.
- R8: `ee_data_in` passes through a two-flop synchronizer. Bit 0 shows the value present two edges earlier, and reads 0 while the port is not owned.
- R9: Bit 6 drives the `ext_req` output. The `ext_ack` input is synchronized through two flops and read in bit 7.
- R10: Writes to bits 7, 4 and 0 have no effect. Writing 0x91 with the port idle and `ext_ack` low leaves the register reading 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| mem_busy | input | 1 | Shared memory port busy with another requester |
| port_owned | output | 1 | Shared port currently held for EEPROM access |
| ext_req | output | 1 | Request to external arbitration logic |
| ext_ack | input | 1 | Acknowledge from external arbitration logic (asynchronous) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_data_out | output | 1 | Serial data to the EEPROM |
| ee_data_in | input | 1 | Serial data from the EEPROM (asynchronous) |

## Verification
An ownership flag stuck low or set too early shows up at once on `port_owned` and on the pins, within one cycle of the change in `mem_busy` or of the request write. A pacing counter that loads wrongly, or is not cleared across a release, appears as ready reading 1 one cycle too early or too late after a write, or as a delayed first ready after a new grant. A fault in the synchronizer depth is seen as bit 0 or bit 7 changing one edge off from the two-edge expectation.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned B_EXT_ACK = 7;
   localparam int unsigned B_EXT_REQ = 6;
   localparam int unsigned B_REQ     = 5;
   localparam int unsigned B_READY   = 4;
   localparam int unsigned B_CS      = 3;
   localparam int unsigned B_SK      = 2;
   localparam int unsigned B_DOUT    = 1;
   localparam int unsigned B_DIN     = 0;

   typedef enum logic [0:0] {
      ARB_IDLE = 1'b0,
      ARB_OWN  = 1'b1
   } arb_state_t;

   typedef struct packed {
      logic ext_req;
      logic req;
      logic cs;
      logic sk;
      logic dout;
   } ctl_bits_t;
endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("seeprom_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("seeprom_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seeprom_arb.sv
module seeprom_arb
   import seeprom_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic busy,
   output logic owned
);
   arb_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_IDLE: if (req && !busy) state_d = ARB_OWN;
         ARB_OWN:  if (!req)         state_d = ARB_IDLE;
         default:                    state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign owned = (state_q == ARB_OWN);

   // R3: ownership is taken only when requested and the shared port is free
   a_r3_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owned) |-> $past(req && !busy));

   // R7: a withdrawn request releases the port on the next edge
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !owned);
endmodule

// File: rtl/seeprom_pace.sv
module seeprom_pace #(
   parameter int unsigned CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clr,
   output logic idle
);
   localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("seeprom_pace: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (load)         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign idle = (cnt_q == '0);

   // R6: once running, the counter steps down by one each cycle
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4: a cleared counter reports idle on the following cycle
   a_r4_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> idle);
endmodule

// File: rtl/seeprom_port.sv
module seeprom_port
   import seeprom_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned PACE_NS     = 800,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   input  logic        mem_busy,
   output logic        port_owned,
   output logic        ext_req,
   input  logic        ext_ack,
   output logic        ee_cs,
   output logic        ee_sk,
   output logic        ee_data_out,
   input  logic        ee_data_in
);
   localparam int unsigned PACE_CYC = (CLK_HZ / 1000) * PACE_NS / 1_000_000;

   if (PACE_CYC < 1) begin : g_bad_pace
      $error("seeprom_port: pacing interval shorter than one clock");
   end
   if (REG_W != 8) begin : g_bad_reg
      $error("seeprom_port: register width must be 8");
   end

   ctl_bits_t ctl_q;
   logic      owned;
   logic      active;
   logic      pace_idle;
   logic      ready;
   logic      pace_load;
   logic [1:0] sync_q;
   logic      ack_s;
   logic      din_s;

   // writable control bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.ext_req <= wr_data[B_EXT_REQ];
         ctl_q.req     <= wr_data[B_REQ];
         ctl_q.cs      <= wr_data[B_CS];
         ctl_q.sk      <= wr_data[B_SK];
         ctl_q.dout    <= wr_data[B_DOUT];
      end
   end

   seeprom_arb u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ctl_q.req),
      .busy  (mem_busy),
      .owned (owned)
   );

   assign active    = owned & ctl_q.req;
   assign pace_load = wr_en & active;

   seeprom_pace #(.CYCLES(PACE_CYC)) u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (pace_load),
      .clr   (!owned),
      .idle  (pace_idle)
   );

   seeprom_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ext_ack, ee_data_in}),
      .q_sync  (sync_q)
   );

   assign ack_s = sync_q[1];
   assign din_s = sync_q[0];
   assign ready = active & pace_idle;

   assign ee_cs       = active & ctl_q.cs;
   assign ee_sk       = active & ctl_q.sk;
   assign ee_data_out = active & ctl_q.dout;
   assign ext_req     = ctl_q.ext_req;
   assign port_owned  = owned;

   always_comb begin
      rd_data            = '0;
      rd_data[B_EXT_ACK] = ack_s;
      rd_data[B_EXT_REQ] = ctl_q.ext_req;
      rd_data[B_REQ]     = ctl_q.req;
      rd_data[B_READY]   = ready;
      rd_data[B_CS]      = ctl_q.cs;
      rd_data[B_SK]      = ctl_q.sk;
      rd_data[B_DOUT]    = ctl_q.dout;
      rd_data[B_DIN]     = active & din_s;
   end

   // R6: a paced write drops ready on its own edge
   a_r6_write_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && active) |=> !rd_data[B_READY]);

   // R5: no chip select unless the port is held
   a_r5_cs_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs |-> port_owned);

   // R4: a fresh grant is ready immediately
   a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(port_owned) && ctl_q.req) |-> rd_data[B_READY]);
endmodule

// File: tb/sim_seeprom_port.sv
module sim_seeprom_port;
   localparam int unsigned PACE = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       mem_busy = 1'b0;
   logic       port_owned;
   logic       ext_req;
   logic       ext_ack = 1'b0;
   logic       ee_cs, ee_sk, ee_data_out;
   logic       ee_data_in = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   seeprom_port u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mem_busy(mem_busy), .port_owned(port_owned),
      .ext_req(ext_req), .ext_ack(ext_ack), .ee_cs(ee_cs), .ee_sk(ee_sk),
      .ee_data_out(ee_data_out), .ee_data_in(ee_data_in)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [2:0] pins_exp(logic act, logic [7:0] v);
      return act ? v[3:1] : 3'b000;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EE9));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 pins", {ee_cs, ee_sk, ee_data_out}, 3'b000);
      check("R1 owned/ext_req", {port_owned, ext_req}, 2'b00);

      // R10 read-only bits ignore writes
      reg_write(8'h91);
      check("R10 ro bits", rd_data, 8'h00);

      // R3 no grant while busy; R2 readback; R5 pins low
      mem_busy = 1'b1;
      reg_write(8'h2E);
      repeat (5) @(negedge clk);
      check("R3 no grant busy", port_owned, 1'b0);
      check("R2 readback", rd_data, 8'h2E);
      check("R5 pins idle", {ee_cs, ee_sk, ee_data_out}, 3'b000);

      // R3/R4 grant and immediate ready
      mem_busy = 1'b0;
      @(negedge clk);
      check("R3 granted", port_owned, 1'b1);
      check("R4 ready at grant", rd_data, 8'h3E);
      check("R5 pins driven", {ee_cs, ee_sk, ee_data_out}, 3'b111);

      // R6 pacing window
      reg_write(8'h28);
      check("R6 ready drop", rd_data, 8'h28);
      repeat (PACE - 1) @(negedge clk);
      check("R6 ready before", rd_data[4], 1'b0);
      @(negedge clk);
      check("R6 ready at end", rd_data[4], 1'b1);
      check("R5 pin map", {ee_cs, ee_sk, ee_data_out}, 3'b100);

      // R8 data-in synchronizer
      ee_data_in = 1'b1;
      @(negedge clk);
      check("R8 din one edge", rd_data[0], 1'b0);
      @(negedge clk);
      check("R8 din two edges", rd_data[0], 1'b1);

      // R9 external handshake
      reg_write(8'h68);
      check("R9 ext_req", ext_req, 1'b1);
      ext_ack = 1'b1;
      @(negedge clk);
      check("R9 ack one edge", rd_data[7], 1'b0);
      @(negedge clk);
      check("R9 ack two edges", rd_data[7], 1'b1);

      // random paced writes while held; mem_busy must not matter (R3)
      for (int i = 0; i < 40; i++) begin
         logic [7:0] v;
         int k;
         v = {1'b0, 1'($urandom), 1'b1, 1'b0, 3'($urandom), 1'b0};
         mem_busy = 1'($urandom);
         reg_write(v);
         check("R5 random pins", {ee_cs, ee_sk, ee_data_out}, pins_exp(1'b1, v));
         check("R2 random readback", {rd_data[6:5], rd_data[3:1]}, {v[6:5], v[3:1]});
         check("R9 random ext_req", ext_req, v[6]);
         k = int'($urandom_range(0, 50));
         repeat (k) @(negedge clk);
         check("R6 random ready", rd_data[4], (k >= PACE) ? 1'b1 : 1'b0);
         check("R3 held", port_owned, 1'b1);
      end
      mem_busy = 1'b0;

      // R7 release
      reg_write(8'h0E);
      check("R7 pins low", {ee_cs, ee_sk, ee_data_out}, 3'b000);
      check("R7 ready low", rd_data[4], 1'b0);
      check("R8 din masked", rd_data[0], 1'b0);
      @(negedge clk);
      check("R7 released", port_owned, 1'b0);

      // R4 re-request: ready without pacing delay
      reg_write(8'h20);
      check("R4 not yet owned", {port_owned, rd_data[4]}, 2'b00);
      @(negedge clk);
      check("R4 ready no delay", {port_owned, rd_data[4]}, 2'b11);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule